// File: doc/BRIEF.md
# Decoded 40-bit Multiply-Accumulate Unit

This block is a signed multiply-accumulate engine with a built-in instruction-field decoder. Each cycle it can take one instruction word and two 32-bit source operands. It checks the word's encoding fields. If the word is well formed, it adds a signed product term into a 40-bit accumulator. Three flavours share one accumulator:

- A full 32x32 product.
- The sum of two packed halfword products.
- A 16x16 product whose halves are chosen by two instruction bits.

A malformed word is not executed. It is reported on a one-cycle illegal-instruction flag, and the accumulator is left as it was. A separate write port loads the accumulator directly. The accumulator is always visible on a read port.

Top module: `mac40_unit`

## Requirements
- R1: While reset is low at a clock edge, the accumulator becomes zero and the illegal flag becomes low.
- R2: With bits [19:18] equal to 0, a legal accepted word adds the full signed 32x32 product of srcA and srcB to the accumulator. The new value is on accOut one clock later.
- R3: With bits [19:18] equal to 2, a legal accepted word adds two products to the accumulator in one update: signed upper half of srcA times signed upper half of srcB, and signed lower half times signed lower half. Each product is sign-extended from 32 bits.
- R4: With bits [19:18] equal to 3, bit 17 picks the upper (1) or lower (0) half of srcA, and bit 16 picks the half of srcB the same way. All four combinations are legal, and the sign-extended 16x16 product is added.
- R5: A word whose bits [11:4] are not exactly 8'h01 is illegal in every form.
- R6: A word with bits [19:18] equal to 1 is illegal. A word with bits [19:18] equal to 0 or 2 and bits [17:16] nonzero is illegal. Bits [31:20], [15:12] and [3:0] are never examined.
- R7: An accepted illegal word raises illegalInst for exactly the next cycle, and the accumulator keeps its value.
- R8: All accumulator updates wrap modulo 2^40, with no saturation.
- R9: With accWrEn high, the accumulator takes accWrData at the edge. This has priority over an instruction in the same cycle, which then leaves no arithmetic effect. An illegal word in that cycle is still flagged.
- R10: With instValid and accWrEn both low, the accumulator holds and illegalInst is low in the next cycle, whatever is on instWord.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instValid | input | 1 | Instruction word present this cycle |
| instWord | input | 32 | Instruction word to decode |
| srcA | input | 32 | First source operand |
| srcB | input | 32 | Second source operand |
| accWrEn | input | 1 | Load accumulator from accWrData |
| accWrData | input | 40 | Value to load into the accumulator |
| accOut | output | 40 | Accumulator read port |
| illegalInst | output | 1 | One-cycle flag for a rejected word |

## Verification
An accumulator load and an accepted instruction can fall in the same cycle. The instruction in that cycle may be legal or malformed. Directed cases put both on one edge with each kind of word, and the random loop adds loads on about one cycle in sixteen on top of a stream of instructions. The result is judged against a bench model in which the loaded value replaces any product term, while the illegal flag still follows the word's encoding.

// File: rtl/mac40_pkg.sv
`timescale 1ns/1ps
package mac40_pkg;
  // Operation field, bits [19:18]
  localparam int OP_LSB = 18;
  localparam logic [1:0] OP_FULL = 2'd0;
  localparam logic [1:0] OP_DUAL = 2'd2;
  localparam logic [1:0] OP_PICK = 2'd3;
  // Half-select bits [17:16]: bit 17 for srcA, bit 16 for srcB
  localparam int SEL_LSB = 16;
  // Fixed tag field [11:4]
  localparam int TAG_LSB = 4;
  localparam int TAG_W = 8;
  localparam logic [TAG_W-1:0] TAG_VAL = 8'h01;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // take write-port value
    logic wide;     // add full-width product
    logic laneHi;   // add upper-half lane product
    logic laneLo;   // add lower/picked lane product
    logic pickHiA;  // lower lane uses upper half of A
    logic pickHiB;  // lower lane uses upper half of B
  } macCtrl_t;
endpackage

// File: rtl/mac40_ctrl.sv
`timescale 1ns/1ps
module mac40_ctrl
  import mac40_pkg::*;
#(
  parameter int INST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  input  logic              accWrEn,
  output macCtrl_t          ctrl,
  output logic              illegalInst
);
  logic [1:0]       opField;
  logic [1:0]       selField;
  logic [TAG_W-1:0] tagField;
  logic             tagOk;
  logic             legal;
  logic             execute;
  logic             unusedFields;

  assign opField  = instWord[OP_LSB +: 2];
  assign selField = instWord[SEL_LSB +: 2];
  assign tagField = instWord[TAG_LSB +: TAG_W];
  assign tagOk    = (tagField == TAG_VAL);
  assign unusedFields = ^{instWord[INST_W-1:OP_LSB+2],
                          instWord[SEL_LSB-1:TAG_LSB+TAG_W],
                          instWord[TAG_LSB-1:0]};

  always_comb begin
    unique case (opField)
      OP_FULL: legal = tagOk && (selField == 2'b00);
      OP_DUAL: legal = tagOk && (selField == 2'b00);
      OP_PICK: legal = tagOk;
      default: legal = 1'b0;
    endcase
  end

  assign execute = instValid && legal && !accWrEn;

  always_comb begin
    ctrl         = '0;
    ctrl.load    = accWrEn;
    ctrl.wide    = execute && (opField == OP_FULL);
    ctrl.laneHi  = execute && (opField == OP_DUAL);
    ctrl.laneLo  = execute && ((opField == OP_DUAL) || (opField == OP_PICK));
    ctrl.pickHiA = (opField == OP_PICK) && selField[1];
    ctrl.pickHiB = (opField == OP_PICK) && selField[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) illegalInst <= 1'b0;
    else        illegalInst <= instValid && !legal;
  end
endmodule

// File: rtl/mac40_lane_mul.sv
`timescale 1ns/1ps
module mac40_lane_mul #(
  parameter int HALF_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic             en,
  input  logic [HALF_W-1:0] opA,
  input  logic [HALF_W-1:0] opB,
  output logic [ACC_W-1:0]  term
);
  localparam int PROD_W = 2 * HALF_W;
  logic signed [PROD_W-1:0] prod;

  assign prod = $signed(opA) * $signed(opB);
  assign term = en ? {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod} : '0;
endmodule

// File: rtl/mac40_datapath.sv
`timescale 1ns/1ps
module mac40_datapath
  import mac40_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  macCtrl_t          ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [ACC_W-1:0]  accWrData,
  output logic [ACC_W-1:0]  accOut
);
  localparam int HALF_W = DATA_W / 2;
  localparam int PROD_W = 2 * DATA_W;
  localparam int LANES  = 2;

  logic [HALF_W-1:0] aHi, aLo, bHi, bLo;
  logic [HALF_W-1:0] laneA [LANES];
  logic [HALF_W-1:0] laneB [LANES];
  logic              laneEn [LANES];
  logic [ACC_W-1:0]  laneTerm [LANES];
  logic signed [PROD_W-1:0] wideProd;
  logic [ACC_W-1:0]  wideTerm;
  logic [ACC_W-1:0]  sum;
  logic              unusedWideHi;

  assign aHi = srcA[DATA_W-1:HALF_W];
  assign aLo = srcA[HALF_W-1:0];
  assign bHi = srcB[DATA_W-1:HALF_W];
  assign bLo = srcB[HALF_W-1:0];

  // lane 0: lower halves, or the picked halves
  assign laneA[0]  = ctrl.pickHiA ? aHi : aLo;
  assign laneB[0]  = ctrl.pickHiB ? bHi : bLo;
  assign laneEn[0] = ctrl.laneLo;
  // lane 1: upper halves
  assign laneA[1]  = aHi;
  assign laneB[1]  = bHi;
  assign laneEn[1] = ctrl.laneHi;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mac40_lane_mul #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_mul (
      .en  (laneEn[g]),
      .opA (laneA[g]),
      .opB (laneB[g]),
      .term(laneTerm[g])
    );
  end

  assign wideProd     = $signed(srcA) * $signed(srcB);
  assign wideTerm     = ctrl.wide ? wideProd[ACC_W-1:0] : '0;
  assign unusedWideHi = ^wideProd[PROD_W-1:ACC_W];
  assign sum          = accOut + wideTerm + laneTerm[0] + laneTerm[1];

  always_ff @(posedge clk) begin
    if (!rst_n)                                   accOut <= '0;
    else if (ctrl.load)                           accOut <= accWrData;
    else if (ctrl.wide || ctrl.laneHi || ctrl.laneLo) accOut <= sum;
  end
endmodule

// File: rtl/mac40_unit.sv
`timescale 1ns/1ps
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              accWrEn,
  input  logic [ACC_W-1:0]  accWrData,
  output logic [ACC_W-1:0]  accOut,
  output logic              illegalInst
);
  macCtrl_t ctrl;

  mac40_ctrl #(.INST_W(32)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .instWord(instWord),
    .accWrEn(accWrEn), .ctrl(ctrl), .illegalInst(illegalInst)
  );

  mac40_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .srcA(srcA), .srcB(srcB),
    .accWrData(accWrData), .accOut(accOut)
  );
endmodule

// File: rtl/mac40_checker.sv
`timescale 1ns/1ps
module mac40_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        instValid,
  input logic [31:0] instWord,
  input logic [31:0] srcA,
  input logic [31:0] srcB,
  input logic        accWrEn,
  input logic [39:0] accWrData,
  input logic [39:0] accOut,
  input logic        illegalInst
);
  logic [63:0] fullProd;
  assign fullProd = $signed(srcA) * $signed(srcB);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (accOut == 40'd0) && !illegalInst);

  assert_full_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && !accWrEn && instWord[19:16] == 4'b0000 && instWord[11:4] == 8'h01)
    |=> accOut == $past(accOut) + $past(fullProd[39:0]));

  assert_bad_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && instWord[11:4] != 8'h01) |=> illegalInst);

  assert_bad_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && (instWord[19:18] == 2'b01 ||
                   (!instWord[18] && instWord[17:16] != 2'b00))) |=> illegalInst);

  assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegalInst |-> $past(instValid));

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (illegalInst && !$past(accWrEn)) |-> $stable(accOut));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accWrEn |=> accOut == $past(accWrData));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!instValid && !accWrEn) |=> $stable(accOut) && !illegalInst);
endmodule

bind mac40_unit mac40_checker u_chk (.*);

// File: tb/mac40_unit_bench.sv
`timescale 1ns/1ps
module mac40_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instValid;
  logic [31:0] instWord;
  logic [31:0] srcA, srcB;
  logic        accWrEn;
  logic [39:0] accWrData;
  logic [39:0] accOut;
  logic        illegalInst;

  int nChecks = 0;
  int nFails  = 0;
  logic [39:0] model = '0;

  always #2.5 clk = ~clk;

  mac40_unit u_mac40_unit (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .instWord(instWord),
    .srcA(srcA), .srcB(srcB), .accWrEn(accWrEn), .accWrData(accWrData),
    .accOut(accOut), .illegalInst(illegalInst)
  );

  function automatic logic [31:0] mkWord(logic [1:0] op, logic [1:0] sel, logic [7:0] tag);
    return {12'hA5C, op, sel, 4'h9, tag, 4'h6};
  endfunction

  function automatic bit isLegal(logic [31:0] w);
    if (w[11:4] != 8'h01) return 0;
    case (w[19:18])
      2'd0, 2'd2: return w[17:16] == 2'b00;
      2'd3:       return 1;
      default:    return 0;
    endcase
  endfunction

  function automatic longint sx16(logic [15:0] h);
    return longint'($signed(h));
  endfunction

  function automatic logic [39:0] delta(logic [31:0] w, logic [31:0] a, logic [31:0] b);
    longint p;
    case (w[19:18])
      2'd0: p = longint'($signed(a)) * longint'($signed(b));
      2'd2: p = sx16(a[31:16]) * sx16(b[31:16]) + sx16(a[15:0]) * sx16(b[15:0]);
      default: p = sx16(w[17] ? a[31:16] : a[15:0]) * sx16(w[16] ? b[31:16] : b[15:0]);
    endcase
    return p[39:0];
  endfunction

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic v, logic [31:0] w, logic [31:0] a,
                      logic [31:0] b, logic we, logic [39:0] wd);
    bit expIll;
    @(negedge clk);
    instValid = v; instWord = w; srcA = a; srcB = b; accWrEn = we; accWrData = wd;
    @(posedge clk); #1;
    expIll = v && !isLegal(w);
    if (we) model = wd;
    else if (v && isLegal(w)) model = model + delta(w, a, b);
    chk({req, " acc"}, accOut, model);
    chk({req, " flag"}, {39'd0, illegalInst}, {39'd0, expIll});
  endtask

  initial begin
    #(5.0 * 200000);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; instValid = 0; instWord = 0; srcA = 0; srcB = 0; accWrEn = 0; accWrData = 0;
    repeat (3) @(posedge clk); #1;
    chk("R1 reset acc", accOut, 40'd0);
    chk("R1 reset flag", {39'd0, illegalInst}, 40'd0);
    @(negedge clk); rst_n = 1;

    // R2 full-word, extremes and wrap (R8)
    step("R2 full", 1, mkWord(2'd0, 2'd0, 8'h01), 32'hFFFF_FFFD, 32'h0000_0007, 0, 0);
    step("R8 min*min wrap", 1, mkWord(2'd0, 2'd0, 8'h01), 32'h8000_0000, 32'h8000_0000, 0, 0);
    step("R9 load", 0, 0, 0, 0, 1, 40'hFF_FFFF_FFFF);
    step("R8 wrap to zero", 1, mkWord(2'd3, 2'd0, 8'h01), 32'h1, 32'h1, 0, 0);
    // R3 dual halves
    step("R3 dual", 1, mkWord(2'd2, 2'd0, 8'h01), 32'h8000_7FFF, 32'h8000_8001, 0, 0);
    step("R3 dual mixed", 1, mkWord(2'd2, 2'd0, 8'h01), 32'hFFFE_0003, 32'h0005_FFF9, 0, 0);
    // R4 all four picks
    for (int s = 0; s < 4; s++)
      step("R4 pick", 1, mkWord(2'd3, s[1:0], 8'h01), 32'h8000_0003, 32'h7FFF_FFFE, 0, 0);
    // R5 / R6 / R7 illegal words
    step("R5 tag 02", 1, mkWord(2'd0, 2'd0, 8'h02), 32'h1234, 32'h5678, 0, 0);
    step("R5 tag 00 pick", 1, mkWord(2'd3, 2'd1, 8'h00), 32'h1234, 32'h5678, 0, 0);
    step("R6 op1", 1, mkWord(2'd1, 2'd0, 8'h01), 32'h1234, 32'h5678, 0, 0);
    step("R6 full sel", 1, mkWord(2'd0, 2'd1, 8'h01), 32'h1234, 32'h5678, 0, 0);
    step("R6 dual sel", 1, mkWord(2'd2, 2'd2, 8'h01), 32'h1234, 32'h5678, 0, 0);
    step("R7 flag drops", 0, 0, 0, 0, 0, 0);
    // R9 load with instruction in same cycle
    step("R9 load+legal", 1, mkWord(2'd0, 2'd0, 8'h01), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 40'h12_3456_789A);
    step("R9 load+illegal", 1, mkWord(2'd1, 2'd0, 8'h01), 32'h3, 32'h3, 1, 40'h00_0000_0042);
    // R10 garbage while idle
    step("R10 idle", 0, mkWord(2'd0, 2'd0, 8'h01), 32'hFFFF, 32'hFFFF, 0, 0);
    step("R10 idle bad", 0, mkWord(2'd1, 2'd3, 8'h77), 32'hFFFF, 32'hFFFF, 0, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0]  op  = 2'($urandom);
      logic [1:0]  sel = (op != 2'd3 && ($urandom % 4 != 0)) ? 2'd0 : 2'($urandom);
      logic [7:0]  tag = ($urandom % 8 == 0) ? 8'($urandom) : 8'h01;
      logic [31:0] w   = {12'($urandom), op, sel, 4'($urandom), tag, 4'($urandom)};
      logic [31:0] a   = ($urandom % 10 == 0) ? 32'h8000_8000 : $urandom;
      logic [31:0] b   = ($urandom % 10 == 0) ? 32'h8000_8000 : $urandom;
      logic        we  = ($urandom % 16 == 0);
      step("R2-R9 random", ($urandom % 8 != 0), w, a, b, we, {8'($urandom), 32'($urandom)});
    end

    // reset mid-run
    @(negedge clk); rst_n = 0; instValid = 0; accWrEn = 0;
    @(posedge clk); #1;
    model = '0;
    chk("R1 reset again acc", accOut, 40'd0);
    chk("R1 reset again flag", {39'd0, illegalInst}, 40'd0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule